// File: doc/BRIEF.md
# Autobaud UART Receiver

This block receives a single idle-high asynchronous serial line and learns the bit rate from the line itself, so it has no programmed divisor. Each packet opens with the character 0x55. The receiver times the falling edges of that character against the fast system clock and derives the bit period in clock cycles. It then samples every later character of the packet at the middle of each bit, using that period.

A frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity. Each good character is delivered as a one-cycle strobe together with the byte. A low stop bit raises a one-cycle framing-error strobe instead.

The learned period is published as a count of clock cycles, so a companion transmitter can answer at the same rate. A flag shows when that period is valid. If the line stays idle for more than sixteen bit periods, the packet is taken as finished, and the next falling edge starts a fresh measurement. The remote side may therefore change its rate from one session to the next.

Top module: `autobaud_rx`

## Requirements
- R1: A frame is one low start bit, eight data bits least significant bit first, and a high stop bit; each such frame received while locked yields one `rx_valid` strobe with the byte on `rx_data`.
- R2: From a 0x55 sync character sent at T clocks per bit, `bit_period` becomes T; the sync character itself is never delivered on `rx_valid`, and `bit_period` does not change while `locked` stays high.
- R3: `locked` rises once the stop bit of the sync character is sampled high, stays high through an idle timeout, and clears when a new rate measurement begins.
- R4: While locked, a data frame whose stop bit samples low gives a one-cycle `frame_err` strobe and no `rx_valid`; the receiver stays locked and accepts the next frame.
- R5: A falling edge whose line is high again at the middle of the start bit is discarded with no `rx_valid` and no `frame_err`.
- R6: After more than sixteen bit periods of idle high line, the next falling edge begins a new measurement, and a new rate is learned from it; after a shorter idle, a 0x55 character is delivered as ordinary data.
- R7: A measured period below MIN_PERIOD clocks (default 4) is rejected: `bit_period` keeps its old value and `locked` stays low.
- R8: A sync character whose stop bit samples low raises `frame_err` and leaves `locked` low.
- R9: After reset, `locked`, `rx_valid` and `frame_err` are low and `bit_period` is zero.
- R10: `rx_valid` and `frame_err` are single-cycle strobes and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_valid | output | 1 | One-cycle strobe, a byte was received |
| rx_data | output | 8 | Received byte, valid with `rx_valid` |
| locked | output | 1 | The bit period has been learned and is valid |
| bit_period | output | CNT_W-3 | Learned bit period in clock cycles |
| frame_err | output | 1 | One-cycle strobe, stop bit sampled low |

## Verification
A wrong learned period shows at the ports right away, because `bit_period` is visible once the sync character ends. It also shows within one frame as a wrong byte, since the sampling point drifts by a fraction of a bit on every bit. A sampler that loses count of its bit index either drops the strobe or turns it into a framing error at the next stop bit. A state machine stuck in the wrong mode shows when the next character arrives: either a sync is delivered as data, or data is measured as a sync and `locked` falls. An idle timer that is off by much appears only after the sixteen-bit-period window, so the bench runs idle gaps both well inside and well beyond that window.

// File: rtl/abr_pkg.sv
// Shared definitions for the autobaud receiver.
// Assumes the sync character is 0x55 and the frame holds eight data bits.
package abr_pkg;
    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,  // waiting for the falling edge that opens a sync character
        ST_MEAS  = 3'd1,  // timing the sync character edges
        ST_TAIL  = 3'd2,  // skipping to the sync stop bit and checking it
        ST_IDLE  = 3'd3,  // locked, waiting for a data start bit
        ST_FRAME = 3'd4   // sampling a data frame
    } rx_state_e;

    // Falling edges of 0x55 that follow the start edge (bits 1, 3, 5, 7)
    localparam int unsigned SYNC_EDGES = 4;
    // Start edge to the fourth later edge spans eight bit periods
    localparam int unsigned SYNC_SHIFT = 3;
    // Sample index of the stop bit (0 = start, 1..8 = data)
    localparam int unsigned FRAME_LAST = 9;
    // Idle window is sixteen bit periods
    localparam int unsigned IDLE_SHIFT = 4;
    localparam int unsigned DATA_W     = 8;
endpackage

// File: rtl/abr_line_sync.sv
// Two-flop synchronizer and falling-edge detector for the serial input.
// Assumes the line is idle high, so all flops reset to one.
module abr_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);
    logic [1:0] stage;
    logic       prev;

    // Bring the line into the clock domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= 2'b11;
            prev  <= 1'b1;
        end else begin
            stage <= {stage[0], rx_in};
            prev  <= stage[1];
        end
    end

    assign rx_s = stage[1];
    assign fall = prev & ~stage[1];
endmodule

// File: rtl/abr_rate_meter.sv
// Times the span from the start edge of a sync character to its fourth
// later falling edge (eight bit periods) and reports the bit period.
// Assumes `start` pulses on the start-bit falling edge; a run that
// saturates the counter or yields a period under MIN_PERIOD fails.
module abr_rate_meter
    import abr_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned MIN_PERIOD = 4,
    localparam int unsigned PER_W     = CNT_W - SYNC_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fall,
    output logic             done,
    output logic             fail,
    output logic [PER_W-1:0] period
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [2:0]       EDGE_FIN = 3'(SYNC_EDGES - 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       edges;
    logic             last_edge;
    logic             saturated;
    logic             too_short;

    assign last_edge = busy & fall & (edges == EDGE_FIN);
    assign saturated = busy & (cnt == CNT_MAX);
    assign period    = cnt[CNT_W-1:SYNC_SHIFT];
    assign too_short = period < PER_W'(MIN_PERIOD);
    assign done      = last_edge & ~saturated & ~too_short;
    assign fail      = saturated | (last_edge & too_short);

    // Count cycles and falling edges while a measurement is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            edges <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= CNT_W'(1);
            edges <= '0;
        end else if (busy) begin
            if (done || fail) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
                if (fall) begin
                    edges <= edges + 3'd1;
                end
            end
        end
    end
endmodule

// File: rtl/abr_bit_timer.sv
// Down-counter that ticks once per loaded interval and then once per
// reload interval until halted. A tick occurs in the cycle the count is zero.
// Assumes load and halt never assert together.
module abr_bit_timer #(
    parameter int unsigned TMR_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic [TMR_W-1:0] reload_val,
    input  logic             halt,
    output logic             tick
);
    logic             run;
    logic [TMR_W-1:0] cnt;

    assign tick = run & (cnt == '0);

    // Run, reload on each tick, or stop on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (halt) begin
            run <= 1'b0;
        end else if (load) begin
            run <= 1'b1;
            cnt <= load_val;
        end else if (run) begin
            if (cnt == '0) begin
                cnt <= reload_val;
            end else begin
                cnt <= cnt - TMR_W'(1);
            end
        end
    end
endmodule

// File: rtl/abr_idle_watch.sv
// Counts consecutive high cycles of the line while enabled and flags when
// the run goes beyond `limit` cycles. Assumes `limit` is stable while enabled.
module abr_idle_watch #(
    parameter int unsigned IDLE_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              line_high,
    input  logic [IDLE_W-1:0] limit,
    output logic              timeout
);
    logic [IDLE_W-1:0] cnt;

    assign timeout = enable & line_high & (cnt == limit);

    // Count high cycles, clearing on any low cycle or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || !line_high) begin
            cnt <= '0;
        end else if (cnt != limit) begin
            cnt <= cnt + IDLE_W'(1);
        end
    end
endmodule

// File: rtl/autobaud_rx.sv
// Autobaud serial receiver. It learns the bit period from a 0x55 sync
// character at the start of each packet, then samples later frames at the
// middle of each bit. Assumes an idle-high line and a clock of at least
// MIN_PERIOD cycles per bit.
module autobaud_rx
    import abr_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned MIN_PERIOD = 4,
    localparam int unsigned PER_W     = CNT_W - SYNC_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              locked,
    output logic [PER_W-1:0]  bit_period,
    output logic              frame_err
);
    localparam int unsigned TMR_W  = PER_W + 1;
    localparam int unsigned IDLE_W = PER_W + IDLE_SHIFT + 1;

    rx_state_e         state;
    logic [3:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic [PER_W-1:0]  period_q;
    logic              locked_q;
    logic              valid_q;
    logic              ferr_q;
    logic [DATA_W-1:0] data_q;

    logic              rx_s;
    logic              fall;
    logic              meas_start;
    logic              meas_done;
    logic              meas_fail;
    logic [PER_W-1:0]  meas_period;
    logic              tmr_load;
    logic              tmr_halt;
    logic              tick;
    logic [TMR_W-1:0]  tmr_load_val;
    logic [TMR_W-1:0]  tmr_reload_val;
    logic [IDLE_W-1:0] idle_limit;
    logic              idle_to;
    logic              at_stop;
    logic              at_start;

    abr_line_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_in (rx_line),
        .rx_s  (rx_s),
        .fall  (fall)
    );

    abr_rate_meter #(
        .CNT_W      (CNT_W),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (meas_start),
        .fall   (fall),
        .done   (meas_done),
        .fail   (meas_fail),
        .period (meas_period)
    );

    abr_bit_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_load),
        .load_val   (tmr_load_val),
        .reload_val (tmr_reload_val),
        .halt       (tmr_halt),
        .tick       (tick)
    );

    abr_idle_watch #(
        .IDLE_W (IDLE_W)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (state == ST_IDLE),
        .line_high (rx_s),
        .limit     (idle_limit),
        .timeout   (idle_to)
    );

    assign at_stop    = (bit_idx == 4'(FRAME_LAST));
    assign at_start   = (bit_idx == 4'd0);
    assign meas_start = (state == ST_HUNT) & fall;
    assign idle_limit = IDLE_W'(period_q) << IDLE_SHIFT;

    // Pick the timer intervals: 1.5 periods to the sync stop bit, else half a period.
    always_comb begin
        tmr_reload_val = TMR_W'(period_q) - TMR_W'(1);
        if (state == ST_MEAS) begin
            tmr_load_val = TMR_W'(meas_period) + TMR_W'(meas_period >> 1) - TMR_W'(1);
        end else begin
            tmr_load_val = TMR_W'(period_q >> 1) - TMR_W'(1);
        end
    end

    // Start the timer on a finished measurement or a data start edge; stop it at frame end.
    always_comb begin
        tmr_load = ((state == ST_MEAS) & meas_done) |
                   ((state == ST_IDLE) & fall & ~idle_to);
        tmr_halt = tick & ((state == ST_TAIL) |
                   ((state == ST_FRAME) & (at_stop | (at_start & rx_s))));
    end

    // Main sequencer: measure, check the sync stop, then receive frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            bit_idx  <= '0;
            shreg    <= '0;
            period_q <= '0;
            locked_q <= 1'b0;
            valid_q  <= 1'b0;
            ferr_q   <= 1'b0;
            data_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (fall) begin
                        locked_q <= 1'b0;
                        state    <= ST_MEAS;
                    end
                end
                ST_MEAS: begin
                    if (meas_done) begin
                        period_q <= meas_period;
                        state    <= ST_TAIL;
                    end else if (meas_fail) begin
                        state <= ST_HUNT;
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        if (rx_s) begin
                            locked_q <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            ferr_q <= 1'b1;
                            state  <= ST_HUNT;
                        end
                    end
                end
                ST_IDLE: begin
                    if (idle_to) begin
                        state <= ST_HUNT;
                    end else if (fall) begin
                        bit_idx <= '0;
                        state   <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (tick) begin
                        if (at_start) begin
                            if (rx_s) begin
                                state <= ST_IDLE;
                            end else begin
                                bit_idx <= 4'd1;
                            end
                        end else if (!at_stop) begin
                            shreg   <= {rx_s, shreg[DATA_W-1:1]};
                            bit_idx <= bit_idx + 4'd1;
                        end else begin
                            if (rx_s) begin
                                valid_q <= 1'b1;
                                data_q  <= shreg;
                            end else begin
                                ferr_q <= 1'b1;
                            end
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    assign rx_valid   = valid_q;
    assign rx_data    = data_q;
    assign locked     = locked_q;
    assign bit_period = period_q;
    assign frame_err  = ferr_q;
endmodule

// File: rtl/abr_rx_checker.sv
// Port-level properties of the autobaud receiver, bound to every instance.
// Assumes the synchronous active-low reset of the receiver.
module abr_rx_checker #(
    parameter int unsigned PER_W      = 13,
    parameter int unsigned MIN_PERIOD = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             frame_err,
    input logic             locked,
    input logic [PER_W-1:0] bit_period
);
    // R10: a byte strobe and an error strobe never coincide
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && frame_err));

    // R10: the byte strobe lasts one cycle
    p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4: the error strobe lasts one cycle
    p_ferr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R1: bytes are only delivered with a learned rate
    p_valid_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> locked);

    // R7: a locked period is never below the minimum
    p_lock_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (bit_period >= PER_W'(MIN_PERIOD)));

    // R2: the period holds while lock is kept
    p_period_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(bit_period));
endmodule

bind autobaud_rx abr_rx_checker #(
    .PER_W      (PER_W),
    .MIN_PERIOD (MIN_PERIOD)
) u_abr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .frame_err  (frame_err),
    .locked     (locked),
    .bit_period (bit_period)
);

// File: tb/tb_autobaud_rx.sv
// Directed bench for the autobaud receiver: one task per scenario.
module tb_autobaud_rx;
    localparam int CLK_PERIOD = 10;
    localparam int PER_W      = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_line = 1'b1;
    logic             rx_valid;
    logic [7:0]       rx_data;
    logic             locked;
    logic [PER_W-1:0] bit_period;
    logic             frame_err;

    int   n_checks = 0;
    int   n_errors = 0;
    int   nb = 0;
    int   nf = 0;
    logic [7:0] got [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    autobaud_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .locked     (locked),
        .bit_period (bit_period),
        .frame_err  (frame_err)
    );

    // Record delivered bytes and error strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && nb < 32) begin
                got[nb] = rx_data;
                nb = nb + 1;
            end
            if (frame_err) nf = nf + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input int t, input logic stopv);
        @(negedge clk);
        rx_line = 1'b0;
        wait_cyc(t);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            wait_cyc(t);
        end
        rx_line = stopv;
        wait_cyc(t);
        rx_line = 1'b1;
    endtask

    task automatic expect_byte(input int n0, input logic [7:0] b, input string req);
        check(nb == n0 + 1, req, "byte count", nb, n0 + 1);
        if (nb == n0 + 1) check(got[n0] == b, req, "byte value", got[n0], b);
    endtask

    task automatic t_reset();
        wait_cyc(4);
        check(locked == 1'b0, "R9", "locked after reset", locked, 0);
        check(bit_period == '0, "R9", "period after reset", bit_period, 0);
        check(rx_valid == 1'b0, "R9", "rx_valid after reset", rx_valid, 0);
        check(frame_err == 1'b0, "R9", "frame_err after reset", frame_err, 0);
        rst_n = 1'b1;
        wait_cyc(4);
    endtask

    task automatic t_basic();
        int n0;
        send_frame(8'h55, 16, 1'b1);
        wait_cyc(32);
        check(locked == 1'b1, "R3", "locked after sync", locked, 1);
        check(bit_period == 16, "R2", "learned period", bit_period, 16);
        check(nb == 0, "R2", "sync not delivered", nb, 0);
        n0 = nb;
        send_frame(8'hA3, 16, 1'b1);
        wait_cyc(16);
        send_frame(8'h00, 16, 1'b1);
        wait_cyc(16);
        send_frame(8'hFF, 16, 1'b1);
        wait_cyc(32);
        check(nb == n0 + 3, "R1", "three bytes", nb, n0 + 3);
        check(got[n0] == 8'hA3, "R1", "byte 0", got[n0], 8'hA3);
        check(got[n0+1] == 8'h00, "R1", "byte 1", got[n0+1], 8'h00);
        check(got[n0+2] == 8'hFF, "R1", "byte 2", got[n0+2], 8'hFF);
    endtask

    task automatic t_false_start();
        int n0 = nb;
        int f0 = nf;
        @(negedge clk);
        rx_line = 1'b0;
        wait_cyc(2);
        rx_line = 1'b1;
        wait_cyc(32);
        check(nb == n0, "R5", "no byte from glitch", nb, n0);
        check(nf == f0, "R5", "no error from glitch", nf, f0);
        send_frame(8'h5A, 16, 1'b1);
        wait_cyc(32);
        expect_byte(n0, 8'h5A, "R5");
    endtask

    task automatic t_data_ferr();
        int n0 = nb;
        int f0 = nf;
        send_frame(8'h81, 16, 1'b0);
        wait_cyc(32);
        check(nf == f0 + 1, "R4", "error strobe count", nf, f0 + 1);
        check(nb == n0, "R4", "no byte on bad stop", nb, n0);
        check(locked == 1'b1, "R4", "lock kept", locked, 1);
        send_frame(8'h42, 16, 1'b1);
        wait_cyc(32);
        expect_byte(n0, 8'h42, "R4");
    endtask

    task automatic t_short_idle();
        int n0;
        wait_cyc(10 * 16);
        n0 = nb;
        send_frame(8'h55, 16, 1'b1);
        wait_cyc(32);
        expect_byte(n0, 8'h55, "R6");
        check(bit_period == 16, "R6", "period kept", bit_period, 16);
    endtask

    task automatic t_timeout_noise();
        int n0;
        wait_cyc(20 * 16);
        check(locked == 1'b1, "R3", "lock kept over idle timeout", locked, 1);
        n0 = nb;
        send_frame(8'h55, 2, 1'b1);
        wait_cyc(40);
        check(locked == 1'b0, "R7", "short period not locked", locked, 0);
        check(bit_period == 16, "R7", "period unchanged", bit_period, 16);
        check(nb == n0, "R6", "measured, not delivered", nb, n0);
    endtask

    task automatic t_sync_ferr();
        int f0 = nf;
        send_frame(8'h55, 10, 1'b0);
        wait_cyc(20);
        check(nf == f0 + 1, "R8", "sync stop error", nf, f0 + 1);
        check(locked == 1'b0, "R8", "still unlocked", locked, 0);
    endtask

    task automatic t_relearn();
        int n0;
        wait_cyc(20);
        send_frame(8'h55, 9, 1'b1);
        wait_cyc(18);
        check(bit_period == 9, "R6", "new period", bit_period, 9);
        check(locked == 1'b1, "R3", "relocked", locked, 1);
        n0 = nb;
        send_frame(8'h3C, 9, 1'b1);
        wait_cyc(18);
        expect_byte(n0, 8'h3C, "R6");
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(2);
        check(locked == 1'b0, "R9", "lock cleared by reset", locked, 0);
        check(bit_period == '0, "R9", "period cleared by reset", bit_period, 0);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_false_start();
        t_data_ferr();
        t_short_idle();
        t_timeout_noise();
        t_sync_ferr();
        t_relearn();
        t_reset_mid();
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end
endmodule